// File: doc/BRIEF.md
# Interrupt Cause and Mask Registers

This block holds a 32-bit interrupt cause register together with three mask registers, all reached through a simple synchronous CPU register port. Event lines from other units pulse high to latch bits 31:1 of the cause register. Software clears latched causes by writing zero to them; ones written leave bits as they are. Bit 0 of the cause register is not storage software can change. It always reflects whether any of bits 31:1 is set.

Two request outputs are formed from the cause register. One faces the CPU and is gated by the CPU mask. The other faces the PCI side and is gated by the PCI mask. The third mask, for system errors, is stored and read back only. Each mask drops every bit outside its own implemented field when it is written.

The block has no state machine. Its sequencing is one register update per clock, and the cause update combines event sets, software clears and the summary bit in that single step.

Top module: `irq_ctl_top`

## Requirements
- R1: After reset (rst_n low, asynchronous) every register reads 0 and both request outputs are low.
- R2: A write with reg_sel = 0 (cause) clears each cause bit n in 31:1 whose write-data bit is 0, and leaves bits whose write-data bit is 1 unchanged.
- R3: A high level on evt_i[n] during a clock edge sets cause bit n, and the bit stays set until software clears it.
- R4: When an event and a clearing write hit the same cause bit in the same cycle, the bit ends up set.
- R5: Cause bit 0 always equals the OR of cause bits 31:1, and data written to bit 0 has no effect.
- R6: A write with reg_sel = 1 (CPU mask) stores write data ANDed with 0x3C3FFFFE.
- R7: A write with reg_sel = 2 (PCI mask) stores write data ANDed with 0x03FFFFFE.
- R8: A write with reg_sel = 3 (system-error mask) stores only write-data bits 5:0, all other bits 0.
- R9: cpu_irq_o is the OR over bits 31:1 of cause AND CPU mask, and follows a register update in the same cycle the update becomes visible.
- R10: pci_irq_o is the OR over bits 31:1 of cause AND PCI mask, with the same timing as R9.
- R11: rd_data returns the stored value of the register chosen by reg_sel, combinationally, with no read side effects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 cause, 1 CPU mask, 2 PCI mask, 3 system-error mask |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |
| evt_i | input | 31 | Event lines for cause bits 31:1 |
| cpu_irq_o | output | 1 | Masked request toward the CPU |
| pci_irq_o | output | 1 | Masked request toward the PCI side |

## Verification
A wrong cause bit shows up in the next read of the cause register and, if that bit is unmasked, on a request output in the same cycle the register updates. A stale or miscomputed summary bit is visible on rd_data bit 0 in the very read that follows the faulty update. Mask faults show in two ways: as extra or missing bits on readback right after the write, and as a request that fires or stays silent for an event whose bit sits just outside or inside a mask field.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        SEL_CAUSE     = 2'd0,
        SEL_CPU_MASK  = 2'd1,
        SEL_PCI_MASK  = 2'd2,
        SEL_SERR_MASK = 2'd3
    } reg_sel_e;

    localparam logic [REG_W-1:0] KEEP_CPU  = 32'h3C3F_FFFE;
    localparam logic [REG_W-1:0] KEEP_PCI  = 32'h03FF_FFFE;
    localparam logic [REG_W-1:0] KEEP_SERR = 32'h0000_003F;

    localparam int N_MASK = 3;

    function automatic logic [REG_W-1:0] mask_keep(input int idx);
        case (idx)
            0:       return KEEP_CPU;
            1:       return KEEP_PCI;
            default: return KEEP_SERR;
        endcase
    endfunction

endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_we,
    input  logic [W-1:1] keep_bits,
    input  logic [W-1:1] set_bits,
    output logic [W-1:0] cause_q
);

    logic [W-1:1] upper_d;

    always_comb begin
        upper_d = cause_q[W-1:1];
        if (clr_we) begin
            upper_d = upper_d & keep_bits;
        end
        upper_d = upper_d | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= {upper_d, |upper_d};
        end
    end

    // R2: a clearing write with no event leaves zeros where write data was zero
    a_r2_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((cause_q[W-1:1] & ~$past(keep_bits) & ~$past(set_bits)) == '0));

    // R3: an event bit is set on the edge after it is seen
    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits != '0) |=> ((cause_q[W-1:1] & $past(set_bits)) == $past(set_bits)));

    // R3: without a write no latched bit disappears
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> (($past(cause_q[W-1:1]) & ~cause_q[W-1:1]) == '0));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int             W    = 32,
    parameter logic [W-1:0]   KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wd,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wd & KEEP;
        end
    end

    // R6 R7 R8: the stored value never carries a bit outside the field
    a_r8_field_only: assert property (@(posedge clk) disable iff (!rst_n)
        (q & ~KEEP) == '0);

    // R11: without a write the mask holds its value
    a_r11_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

endmodule

// File: rtl/irq_req_reduce.sv
module irq_req_reduce #(
    parameter int W = 32
) (
    input  logic [W-1:1] cause_bits,
    input  logic [W-1:1] mask_bits,
    output logic         req
);

    always_comb begin
        req = |(cause_bits & mask_bits);
    end

endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
    import irq_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic [REG_W-1:1]  evt_i,
    output logic              cpu_irq_o,
    output logic              pci_irq_o
);

    logic [REG_W-1:0] cause_q;
    logic [REG_W-1:0] mask_q [N_MASK];
    logic             cause_we;
    reg_sel_e         sel;

    assign sel      = reg_sel_e'(reg_sel);
    assign cause_we = wr_en && (sel == SEL_CAUSE);

    irq_cause_reg #(.W(REG_W)) u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_we    (cause_we),
        .keep_bits (wr_data[REG_W-1:1]),
        .set_bits  (evt_i),
        .cause_q   (cause_q)
    );

    for (genvar gi = 0; gi < N_MASK; gi++) begin : g_mask
        localparam logic [REG_W-1:0] KEEP_G = mask_keep(gi);
        logic we_g;
        assign we_g = wr_en && (reg_sel == 2'(gi + 1));
        irq_mask_reg #(.W(REG_W), .KEEP(KEEP_G)) u_mask (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_g),
            .wd    (wr_data),
            .q     (mask_q[gi])
        );
    end

    irq_req_reduce #(.W(REG_W)) u_cpu_req (
        .cause_bits (cause_q[REG_W-1:1]),
        .mask_bits  (mask_q[0][REG_W-1:1]),
        .req        (cpu_irq_o)
    );

    irq_req_reduce #(.W(REG_W)) u_pci_req (
        .cause_bits (cause_q[REG_W-1:1]),
        .mask_bits  (mask_q[1][REG_W-1:1]),
        .req        (pci_irq_o)
    );

    always_comb begin
        unique case (sel)
            SEL_CAUSE:     rd_data = cause_q;
            SEL_CPU_MASK:  rd_data = mask_q[0];
            SEL_PCI_MASK:  rd_data = mask_q[1];
            SEL_SERR_MASK: rd_data = mask_q[2];
            default:       rd_data = '0;
        endcase
    end

    // R5: reading the cause register shows a consistent summary bit
    a_r5_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_CAUSE) |-> (rd_data[0] == |rd_data[REG_W-1:1]));

    // R9: a CPU request implies a pending cause
    a_r9_cpu_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq_o |-> cause_q[0]);

    // R10: a PCI request implies a pending cause
    a_r10_pci_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
        pci_irq_o |-> cause_q[0]);

endmodule

// File: tb/irq_ctl_top_tb.sv
module irq_ctl_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:1] evt_i = '0;
    logic        cpu_irq_o;
    logic        pci_irq_o;

    always #5 clk = ~clk;

    irq_ctl_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .evt_i     (evt_i),
        .cpu_irq_o (cpu_irq_o),
        .pci_irq_o (pci_irq_o)
    );

    typedef struct {
        logic [31:0] rd;
        logic        cpu;
        logic        pci;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] m_cause = '0;
    logic [31:0] m_cpu = '0;
    logic [31:0] m_pci = '0;
    logic [31:0] m_serr = '0;

    function automatic logic [31:0] model_rd(input logic [1:0] s);
        case (s)
            2'd0: return m_cause;
            2'd1: return m_cpu;
            2'd2: return m_pci;
            default: return m_serr;
        endcase
    endfunction

    // monitor: compares combinational outputs at the falling edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (rd_data !== e.rd || cpu_irq_o !== e.cpu || pci_irq_o !== e.pci) begin
                fails++;
                $display("FAIL %s rd=%h cpu=%b pci=%b expected rd=%h cpu=%b pci=%b",
                         e.tag, rd_data, cpu_irq_o, pci_irq_o, e.rd, e.cpu, e.pci);
            end
        end
    end

    task automatic expect_rd(input logic [1:0] s, input string tag);
        exp_t e;
        reg_sel = s;
        e.rd  = model_rd(s);
        e.cpu = |(m_cause[31:1] & m_cpu[31:1]);
        e.pci = |(m_cause[31:1] & m_pci[31:1]);
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    // one clock: optional write plus events, then update the bench model
    task automatic cyc(input logic we, input logic [1:0] s,
                       input logic [31:0] wd, input logic [31:1] ev);
        logic [31:1] up;
        @(posedge clk);
        #1;
        wr_en = we; reg_sel = s; wr_data = wd; evt_i = ev;
        @(posedge clk);
        #1;
        wr_en = 1'b0; evt_i = '0;
        up = m_cause[31:1];
        if (we) begin
            case (s)
                2'd0: up = up & wd[31:1];
                2'd1: m_cpu = wd & 32'h3C3F_FFFE;
                2'd2: m_pci = wd & 32'h03FF_FFFE;
                default: m_serr = wd & 32'h0000_003F;
            endcase
        end
        up = up | ev;
        m_cause = {up, |up};
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        for (int s = 0; s < 4; s++) expect_rd(2'(s), "R1 reset in progress");
        rst_n = 1'b1;
        for (int s = 0; s < 4; s++) expect_rd(2'(s), "R1 after reset");

        // R6 R7 R8: mask fields
        cyc(1'b1, 2'd1, 32'hFFFF_FFFF, '0);
        expect_rd(2'd1, "R6 cpu mask field");
        cyc(1'b1, 2'd2, 32'hFFFF_FFFF, '0);
        expect_rd(2'd2, "R7 pci mask field");
        cyc(1'b1, 2'd3, 32'hFFFF_FFFF, '0);
        expect_rd(2'd3, "R8 serr mask field");
        cyc(1'b1, 2'd3, 32'hA5A5_5A5A, '0);
        expect_rd(2'd3, "R8 serr mask pattern");

        // R3 R9 R10: event sets cause, both requests rise
        cyc(1'b0, 2'd0, '0, 31'(1 << 4));
        expect_rd(2'd0, "R3 R5 R9 R10 event bit 5");
        cyc(1'b0, 2'd0, '0, 31'(1 << 29));
        cyc(1'b0, 2'd0, '0, '0);
        cyc(1'b0, 2'd0, '0, '0);
        expect_rd(2'd0, "R3 sticky bits 5 and 30");

        // R2: clear bit 5 only, masked bit 30 remains, requests drop
        cyc(1'b1, 2'd0, 32'hFFFF_FFDF, '0);
        expect_rd(2'd0, "R2 R9 R10 clear bit 5");

        // R9 R10: bit 27 in cpu field only
        cyc(1'b0, 2'd0, '0, 31'(1 << 26));
        expect_rd(2'd0, "R9 R10 bit 27 cpu only");

        // R4: clear-all with simultaneous event on bit 3
        cyc(1'b1, 2'd0, 32'h0000_0000, 31'(1 << 2));
        expect_rd(2'd0, "R4 set wins over clear");

        // R5: writing bit 0 alone clears everything, summary follows
        cyc(1'b1, 2'd0, 32'h0000_0001, '0);
        expect_rd(2'd0, "R5 bit0 write ignored");

        // R9 R10: cpu mask off, pci still on
        cyc(1'b1, 2'd1, 32'h0000_0000, '0);
        cyc(1'b0, 2'd0, '0, 31'(1 << 2));
        expect_rd(2'd0, "R9 R10 cpu masked pci pass");
        expect_rd(2'd1, "R11 cpu mask readback");
        expect_rd(2'd2, "R11 pci mask readback");
        expect_rd(2'd0, "R11 read has no side effect");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule